// File: doc/BRIEF.md
# Parallel DAC Write Sequencer

This block sits on the host side of an eight-channel, 13-bit parallel-input converter bank. It takes one request at a time from a valid/ready command port and turns it into a timed sequence on the converter's bus. That bus consists of a channel address, a data word, and four active-low strobes: chip select, write, load and clear. Each request names a channel and a code. It can also ask for a simultaneous update of all channels, for a clear pulse, or for a settling wait before completion is reported.

Every minimum interface time is given in nanoseconds as a parameter. Each one is turned into a whole number of system clock cycles by rounding up, with a floor of one cycle. The write strobe low phase lasts as long as the longest of four limits: chip select low time, write low time, address setup and data setup. Address and data are driven when the strobes fall and held until after they rise. So every setup limit is met, and every zero-hold limit is met with margin.

A plain write pulses chip select and write together. An update request follows the write with one load pulse, and the load strobe falls only after chip select and write have both been high for a full cycle. A clear request pulses only the clear strobe. The optional settling wait holds busy for a further parameterised time, and a one-cycle done pulse marks the end of every request.

Top module: `dac_bus_sequencer`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `dac_cs_n`, `dac_wr_n`, `dac_ldac_n` and `dac_clr_n` are all 1, and `cmd_ready` is 1.
- R2: On a write, `dac_cs_n` and `dac_wr_n` fall on the same edge and rise on the same edge. They stay low for STROBE cycles, the largest of the rounded-up chip-select low, write low, address setup and data setup times (10 cycles at 5 ns with the defaults).
- R3: While the write strobe is low and on the cycle it rises, `dac_addr` equals the requested channel number (binary, channel 0 = 0) and `dac_data` equals the requested 13-bit code, with neither changing.
- R4: When `cmd_update` is 1 and `cmd_clear` is 0, a single `dac_ldac_n` low pulse of the rounded-up load width (10 cycles) follows the write. It falls only after `dac_cs_n` and `dac_wr_n` have been high for at least one full cycle.
- R5: When `cmd_clear` is 1, only `dac_clr_n` pulses low, for the rounded-up clear width (60 cycles). No write and no load pulse take place, whatever `cmd_update` is.
- R6: When `cmd_settle` is 1, `busy` stays high for the rounded-up settling time after the last strobe has risen.
- R7: `busy` rises on the edge that accepts a request (`cmd_valid` and `cmd_ready` both 1). It falls on the edge where the last strobe rises, or where the settle wait ends. `done` is high for exactly the one cycle after `busy` falls.
- R8: While `busy` is 1, `cmd_ready` is 0 and a request held valid is not taken. The channel, code and flags used are those present on the accepting edge.
- R9: Each cycle count equals the ceiling of the time in ns times 1000 divided by `CLK_PS`, and is never less than 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Request can be accepted (idle) |
| cmd_chan | input | ADDR_W | Target channel |
| cmd_code | input | CODE_W | Code to write |
| cmd_update | input | 1 | Follow the write with a load pulse |
| cmd_clear | input | 1 | Issue a clear pulse instead of a write |
| cmd_settle | input | 1 | Wait the settling time before done |
| dac_addr | output | ADDR_W | Channel address bus |
| dac_data | output | CODE_W | Data bus |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_ldac_n | output | 1 | Simultaneous load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that reset is held from time zero until the first edges have passed, so that no `$past` term reads a value from before reset. They also assume that a request's flags are meaningful only on the accepting edge. The bench therefore drives every input on the falling clock edge and starts every request from idle. Where it holds `cmd_valid` high through a busy period, it changes the channel and code, and it withdraws `cmd_valid` on the first falling edge after `busy` drops, so that no second request is accepted by accident.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_LDGAP,
        ST_LOAD,
        ST_CLEAR,
        ST_SETTLE
    } seq_state_e;

    typedef struct packed {
        logic upd;
        logic settle;
    } req_flags_t;

    // nanoseconds to clock cycles, rounded up, at least one cycle
    function automatic int ns_to_cycles(input int ns, input int clk_ps);
        int c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dac_seq_req_reg.sv
module dac_seq_req_reg
    import dac_seq_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CODE_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] chan_in,
    input  logic [CODE_W-1:0] code_in,
    input  req_flags_t        flags_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CODE_W-1:0] data_q,
    output req_flags_t        flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            data_q  <= '0;
            flags_q <= '0;
        end else if (capture) begin
            addr_q  <= chan_in;
            data_q  <= code_in;
            flags_q <= flags_in;
        end
    end

endmodule

// File: rtl/dac_seq_timer.sv
module dac_seq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
    import dac_seq_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int STROBE_CYC = 10,
    parameter int LD_CYC     = 10,
    parameter int CLR_CYC    = 60,
    parameter int SETTLE_CYC = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic             cmd_clear,
    input  req_flags_t       held,
    input  logic             tmr_expired,
    output logic             accept,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             cs_n,
    output logic             wr_n,
    output logic             ldac_n,
    output logic             clr_n,
    output logic             busy,
    output logic             done
);

    localparam logic [CNT_W-1:0] STR_M1 = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_M1  = CNT_W'(LD_CYC - 1);
    localparam logic [CNT_W-1:0] CLR_M1 = CNT_W'(CLR_CYC - 1);
    localparam logic [CNT_W-1:0] SET_M1 = CNT_W'(SETTLE_CYC - 1);

    seq_state_e st_q, st_d;
    logic cs_d, wr_d, ld_d, clr_d, busy_d, done_d;
    logic finish;

    assign accept = cmd_valid && (st_q == ST_IDLE);

    always_comb begin
        st_d     = st_q;
        cs_d     = cs_n;
        wr_d     = wr_n;
        ld_d     = ldac_n;
        clr_d    = clr_n;
        busy_d   = busy;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        finish   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (cmd_valid) begin
                    busy_d   = 1'b1;
                    tmr_load = 1'b1;
                    if (cmd_clear) begin
                        st_d    = ST_CLEAR;
                        clr_d   = 1'b0;
                        tmr_val = CLR_M1;
                    end else begin
                        st_d    = ST_STROBE;
                        cs_d    = 1'b0;
                        wr_d    = 1'b0;
                        tmr_val = STR_M1;
                    end
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    cs_d = 1'b1;
                    wr_d = 1'b1;
                    if (held.upd) st_d = ST_LDGAP;
                    else          finish = 1'b1;
                end
            end
            ST_LDGAP: begin
                ld_d     = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = LD_M1;
                st_d     = ST_LOAD;
            end
            ST_LOAD: begin
                if (tmr_expired) begin
                    ld_d   = 1'b1;
                    finish = 1'b1;
                end
            end
            ST_CLEAR: begin
                if (tmr_expired) begin
                    clr_d  = 1'b1;
                    finish = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    st_d   = ST_IDLE;
                    busy_d = 1'b0;
                    done_d = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
        if (finish) begin
            if (held.settle) begin
                st_d     = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = SET_M1;
            end else begin
                st_d   = ST_IDLE;
                busy_d = 1'b0;
                done_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cs_n   <= 1'b1;
            wr_n   <= 1'b1;
            ldac_n <= 1'b1;
            clr_n  <= 1'b1;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cs_n   <= cs_d;
            wr_n   <= wr_d;
            ldac_n <= ld_d;
            clr_n  <= clr_d;
            busy   <= busy_d;
            done   <= done_d;
        end
    end

endmodule

// File: rtl/dac_bus_sequencer.sv
module dac_bus_sequencer
    import dac_seq_pkg::*;
#(
    parameter int CLK_PS        = 5000,
    parameter int ADDR_W        = 3,
    parameter int CODE_W        = 13,
    parameter int T_ADDR_SU_NS  = 20,
    parameter int T_CS_LOW_NS   = 50,
    parameter int T_WR_LOW_NS   = 50,
    parameter int T_DATA_SU_NS  = 25,
    parameter int T_LD_LOW_NS   = 50,
    parameter int T_CLR_LOW_NS  = 300,
    parameter int T_SETTLE_NS   = 15000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_chan,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_update,
    input  logic              cmd_clear,
    input  logic              cmd_settle,
    output logic [ADDR_W-1:0] dac_addr,
    output logic [CODE_W-1:0] dac_data,
    output logic              dac_cs_n,
    output logic              dac_wr_n,
    output logic              dac_ldac_n,
    output logic              dac_clr_n,
    output logic              busy,
    output logic              done
);

    localparam int STROBE_CYC = imax(imax(ns_to_cycles(T_CS_LOW_NS, CLK_PS),
                                          ns_to_cycles(T_WR_LOW_NS, CLK_PS)),
                                     imax(ns_to_cycles(T_ADDR_SU_NS, CLK_PS),
                                          ns_to_cycles(T_DATA_SU_NS, CLK_PS)));
    localparam int LD_CYC     = ns_to_cycles(T_LD_LOW_NS, CLK_PS);
    localparam int CLR_CYC    = ns_to_cycles(T_CLR_LOW_NS, CLK_PS);
    localparam int SETTLE_CYC = ns_to_cycles(T_SETTLE_NS, CLK_PS);
    localparam int MAX_CYC    = imax(imax(STROBE_CYC, LD_CYC), imax(CLR_CYC, SETTLE_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1);

    logic             accept;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    req_flags_t       flags_in;
    req_flags_t       flags_q;

    assign flags_in.upd    = cmd_update;
    assign flags_in.settle = cmd_settle;
    assign cmd_ready       = !busy;

    dac_seq_req_reg #(
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) u_req (
        .clk      (clk),
        .rst      (rst),
        .capture  (accept),
        .chan_in  (cmd_chan),
        .code_in  (cmd_code),
        .flags_in (flags_in),
        .addr_q   (dac_addr),
        .data_q   (dac_data),
        .flags_q  (flags_q)
    );

    dac_seq_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    dac_seq_ctrl #(
        .CNT_W      (CNT_W),
        .STROBE_CYC (STROBE_CYC),
        .LD_CYC     (LD_CYC),
        .CLR_CYC    (CLR_CYC),
        .SETTLE_CYC (SETTLE_CYC)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd_clear   (cmd_clear),
        .held        (flags_q),
        .tmr_expired (tmr_expired),
        .accept      (accept),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .cs_n        (dac_cs_n),
        .wr_n        (dac_wr_n),
        .ldac_n      (dac_ldac_n),
        .clr_n       (dac_clr_n),
        .busy        (busy),
        .done        (done)
    );

endmodule

// File: rtl/dac_seq_checker.sv
module dac_seq_checker #(
    parameter int ADDR_W  = 3,
    parameter int CODE_W  = 13,
    parameter int STR_MIN = 10,
    parameter int LD_MIN  = 10,
    parameter int CLR_MIN = 60
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              busy,
    input logic              done,
    input logic              cs_n,
    input logic              wr_n,
    input logic              ldac_n,
    input logic              clr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [CODE_W-1:0] data
);

    int wr_run, ld_run, clr_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_run  <= 0;
            ld_run  <= 0;
            clr_run <= 0;
        end else begin
            wr_run  <= wr_n   ? 0 : wr_run + 1;
            ld_run  <= ldac_n ? 0 : ld_run + 1;
            clr_run <= clr_n  ? 0 : clr_run + 1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cs_n && wr_n && ldac_n && clr_n && cmd_ready));

    p_cs_wr_pair_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n == wr_n);

    p_wr_width_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_n && wr_run != 0) |-> (wr_run >= STR_MIN));

    p_bus_stable_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!wr_n) |-> ($stable(addr) && $stable(data)));

    p_ld_width_r4: assert property (@(posedge clk) disable iff (rst)
        (ldac_n && ld_run != 0) |-> (ld_run >= LD_MIN));

    p_ld_after_wr_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(ldac_n) |-> (wr_n && $past(wr_n)));

    p_clr_width_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_n && clr_run != 0) |-> (clr_run >= CLR_MIN));

    p_clr_alone_r5: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (wr_n && ldac_n));

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_refuse_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> !cmd_ready);

endmodule

bind dac_bus_sequencer dac_seq_checker #(
    .ADDR_W  (ADDR_W),
    .CODE_W  (CODE_W),
    .STR_MIN (STROBE_CYC),
    .LD_MIN  (LD_CYC),
    .CLR_MIN (CLR_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .done      (done),
    .cs_n      (dac_cs_n),
    .wr_n      (dac_wr_n),
    .ldac_n    (dac_ldac_n),
    .clr_n     (dac_clr_n),
    .addr      (dac_addr),
    .data      (dac_data)
);

// File: tb/dac_bus_sequencer_tb.sv
module dac_bus_sequencer_tb;

    localparam int CLK_PS   = 5000;
    localparam int SET_NS   = 400;
    localparam int ADDR_W   = 3;
    localparam int CODE_W   = 13;

    function automatic int ceil_cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    // expected counts from the requirement arithmetic
    int e_str, e_ld, e_clr, e_set;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [ADDR_W-1:0] cmd_chan = '0;
    logic [CODE_W-1:0] cmd_code = '0;
    logic cmd_update = 1'b0, cmd_clear = 1'b0, cmd_settle = 1'b0;
    logic [ADDR_W-1:0] dac_addr;
    logic [CODE_W-1:0] dac_data;
    logic dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n, busy, done;

    always #2.5 clk = ~clk;

    dac_bus_sequencer #(
        .CLK_PS      (CLK_PS),
        .ADDR_W      (ADDR_W),
        .CODE_W      (CODE_W),
        .T_SETTLE_NS (SET_NS)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_ready  (cmd_ready),
        .cmd_chan   (cmd_chan),
        .cmd_code   (cmd_code),
        .cmd_update (cmd_update),
        .cmd_clear  (cmd_clear),
        .cmd_settle (cmd_settle),
        .dac_addr   (dac_addr),
        .dac_data   (dac_data),
        .dac_cs_n   (dac_cs_n),
        .dac_wr_n   (dac_wr_n),
        .dac_ldac_n (dac_ldac_n),
        .dac_clr_n  (dac_clr_n),
        .busy       (busy),
        .done       (done)
    );

    int n_chk = 0, n_err = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bus monitor, sampling on the falling edge
    int wr_run = 0, cs_run = 0, ld_run = 0, clr_run = 0, busy_run = 0;
    int wr_len, cs_len, ld_len, clr_len, busy_len;
    int wr_cnt = 0, ld_cnt = 0, clr_cnt = 0, done_cnt = 0;
    int stab_err = 0, pair_err = 0, gap_err = 0, ready_err = 0, idle_err = 0;
    int cap_addr, cap_data;
    logic prev_wr = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (dac_cs_n != dac_wr_n) pair_err++;
            if (busy && cmd_ready) ready_err++;
            if (!busy && !(dac_cs_n && dac_wr_n && dac_ldac_n && dac_clr_n && cmd_ready))
                idle_err++;
            if (done) done_cnt++;
            if (!dac_wr_n) begin
                if (wr_run == 0) begin
                    cap_addr = int'(dac_addr);
                    cap_data = int'(dac_data);
                end else if (int'(dac_addr) != cap_addr || int'(dac_data) != cap_data) begin
                    stab_err++;
                end
                wr_run++;
            end else if (wr_run != 0) begin
                if (int'(dac_addr) != cap_addr || int'(dac_data) != cap_data) stab_err++;
                wr_len = wr_run; wr_cnt++; wr_run = 0;
            end
            if (!dac_cs_n) cs_run++;
            else if (cs_run != 0) begin cs_len = cs_run; cs_run = 0; end
            if (!dac_ldac_n) begin
                if (ld_run == 0 && !(dac_wr_n && prev_wr)) gap_err++;
                ld_run++;
            end else if (ld_run != 0) begin ld_len = ld_run; ld_cnt++; ld_run = 0; end
            if (!dac_clr_n) clr_run++;
            else if (clr_run != 0) begin clr_len = clr_run; clr_cnt++; clr_run = 0; end
            if (busy) busy_run++;
            else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
            prev_wr = dac_wr_n;
        end
    end

    // one request from idle; pester keeps valid high with new fields while busy
    task automatic issue(input int ch, input int code, input bit upd, input bit clr,
                         input bit wt, input bit pester);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_chan   = ADDR_W'(ch);
        cmd_code   = CODE_W'(code);
        cmd_update = upd;
        cmd_clear  = clr;
        cmd_settle = wt;
        @(posedge clk);
        @(negedge clk);
        if (pester) begin
            cmd_chan   = ~cmd_chan;
            cmd_code   = ~cmd_code;
            cmd_update = ~upd;
            cmd_clear  = ~clr;
        end else begin
            cmd_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        cmd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int codes[4];
        int w0, l0, c0, d0;
        e_str = ceil_cyc(50);
        if (ceil_cyc(20) > e_str) e_str = ceil_cyc(20);
        if (ceil_cyc(25) > e_str) e_str = ceil_cyc(25);
        e_ld  = ceil_cyc(50);
        e_clr = ceil_cyc(300);
        e_set = ceil_cyc(SET_NS);

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes idle", int'({dac_cs_n, dac_wr_n, dac_ldac_n, dac_clr_n}), 15);
        chk("R1 busy low", int'(busy), 0);
        chk("R1 ready high", int'(cmd_ready), 1);

        // plain writes, all channels, several codes
        for (int ch = 0; ch < 8; ch++) begin
            codes[0] = 0;
            codes[1] = 8191;
            codes[2] = 12'hAAA ^ (ch * 37);
            codes[3] = 1 << (ch + 5);
            for (int k = 0; k < 4; k++) begin
                w0 = wr_cnt; l0 = ld_cnt; d0 = done_cnt;
                issue(ch, codes[k], 1'b0, 1'b0, 1'b0, 1'b0);
                chk("R2 one write", wr_cnt - w0, 1);
                chk("R2 wr low cycles", wr_len, e_str);
                chk("R2 cs low cycles", cs_len, e_str);
                chk("R3 address", cap_addr, ch);
                chk("R3 data", cap_data, codes[k]);
                chk("R4 no load on plain write", ld_cnt - l0, 0);
                chk("R7 busy cycles", busy_len, e_str);
                chk("R7 one done", done_cnt - d0, 1);
            end
        end

        // writes with simultaneous update
        for (int ch = 0; ch < 8; ch++) begin
            w0 = wr_cnt; l0 = ld_cnt;
            issue(ch, ch * 1000 + 7, 1'b1, 1'b0, 1'b0, 1'b0);
            chk("R4 write before load", wr_cnt - w0, 1);
            chk("R4 one load", ld_cnt - l0, 1);
            chk("R4 load low cycles", ld_len, e_ld);
            chk("R3 address upd", cap_addr, ch);
            chk("R7 busy cycles upd", busy_len, e_str + 1 + e_ld);
        end

        // clear, with and without update flag
        for (int u = 0; u < 2; u++) begin
            w0 = wr_cnt; l0 = ld_cnt; c0 = clr_cnt;
            issue(5, 4321, u[0], 1'b1, 1'b0, 1'b0);
            chk("R5 one clear", clr_cnt - c0, 1);
            chk("R5 clear low cycles", clr_len, e_clr);
            chk("R5 no write", wr_cnt - w0, 0);
            chk("R5 no load", ld_cnt - l0, 0);
            chk("R9 clear rounding busy", busy_len, e_clr);
        end

        // settling wait on each kind of request
        issue(2, 100, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 settle after write", busy_len, e_str + e_set);
        issue(6, 200, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R6 settle after load", busy_len, e_str + 1 + e_ld + e_set);
        issue(1, 0, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6 settle after clear", busy_len, e_clr + e_set);

        // request held valid through busy with changed fields
        w0 = wr_cnt; l0 = ld_cnt; c0 = clr_cnt; d0 = done_cnt;
        issue(3, 13'h123, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8 single write", wr_cnt - w0, 1);
        chk("R8 latched address", cap_addr, 3);
        chk("R8 latched data", cap_data, 13'h123);
        chk("R8 no extra load", ld_cnt - l0, 0);
        chk("R8 no extra clear", clr_cnt - c0, 0);
        chk("R8 single done", done_cnt - d0, 1);

        chk("R2 cs and wr paired", pair_err, 0);
        chk("R3 bus stable", stab_err, 0);
        chk("R4 load gap", gap_err, 0);
        chk("R8 ready low while busy", ready_err, 0);
        chk("R1 idle strobes high", idle_err, 0);
        finish_run();
    end

endmodule